// File: doc/BRIEF.md
# Piecewise-Linear Gamma Curve

This block maps one 12-bit linear pixel sample per clock to a 10-bit display sample. It uses a single curve of 33 knots. The knot positions along the input axis are fixed: eight steps of 8 cover inputs 0 to 64. Above that, each power-of-two octave (64–128, 128–256 and so on up to 2048–4096) is split into four equal steps. Every segment is therefore a power of two wide, so the block interpolates with one signed multiply and a right shift. The output level at each knot is a programmable 10-bit value.

Knot values are written through a simple write port into a pending bank. They are copied into the bank the datapath reads only while no frame is in progress, so a frame is never processed with a half-updated curve. A fade-to-black control, taken in at the same frame boundary, makes the whole curve evaluate to zero. Samples pass through a fixed two-stage pipeline, and a valid flag travels alongside them.

Top module: `gamma_pwl`

## Requirements
- R1: For input x in segment k, with knot x[k] <= x < x[k+1], width w = x[k+1] - x[k] and knot outputs y[k], y[k+1], the output is y[k] + floor((y[k+1] - y[k]) * (x - x[k]) / w). The knot positions are 0, 8, 16, 24, 32, 40, 48, 56, 64, 80, 96, 112, 128, 160, 192, 224, 256, 320, 384, 448, 512, 640, 768, 896, 1024, 1280, 1536, 1792, 2048, 2560, 3072, 3584 and 4096.
- R2: An input equal to a knot position returns exactly that knot's value. Input 4095 is evaluated in the last segment (3584 to 4096).
- R3: Knot values need not rise. A falling segment interpolates downward, and every result lies between the two endpoint values of its segment, within 0 to 1023.
- R4: out_valid equals in_valid delayed by exactly two clock cycles. The result for a sample appears on out_sample in the same cycle that its out_valid is high.
- R5: While fade-to-black is in effect, the output is 0 for every input.
- R6: A write with wr_en high and wr_addr from 0 to 32 sets the value of knot wr_addr to wr_data. A write to wr_addr 33 to 63 changes no knot.
- R7: Knot writes and changes of fade_black made while frame_active is high do not affect samples until frame_active has been low for a clock edge. They then take effect.
- R8: After reset, all knot values are 0, fade is off, out_valid is 0, and every sample maps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_active | input | 1 | High while a frame is streaming; pending curve changes apply only while low |
| fade_black | input | 1 | Requests an all-zero curve |
| wr_en | input | 1 | Knot write strobe |
| wr_addr | input | 6 | Knot index to write |
| wr_data | input | 10 | Knot output value |
| in_valid | input | 1 | Input sample valid |
| in_sample | input | 12 | Linear input sample |
| out_valid | output | 1 | Output sample valid |
| out_sample | output | 10 | Gamma-mapped sample |

## Verification
The hardest case to reach from the ports is a curve change that arrives in the middle of a frame. This includes a fade request. The change must stay invisible while samples keep flowing, and then appear after the frame boundary. The stimulus raises frame_active, writes new knot values and asserts fade_black while random samples stream, and checks that the old curve is still in use. It then drops frame_active and streams again to see the fade applied, and finally the new knots. Falling segments and exact knot positions are covered by a descending directed curve, by samples placed on every knot and one step past it, and by random non-monotonic curves.

// File: rtl/gamma_pkg.sv
package gamma_pkg;
  localparam int IN_W       = 12;
  localparam int OUT_W      = 10;
  localparam int FINE_LOG   = 3;
  localparam int FINE_SEGS  = 8;
  localparam int SUBDIV_LOG = 2;
  localparam int SUBDIV     = 1 << SUBDIV_LOG;
  localparam int OCT_FIRST  = FINE_LOG + $clog2(FINE_SEGS);
  localparam int NSEG       = FINE_SEGS + (IN_W - OCT_FIRST) * SUBDIV;
  localparam int NKNOT      = NSEG + 1;
  localparam int SEG_W      = $clog2(NSEG);
  localparam int ADDR_W     = $clog2(NKNOT);
  localparam int SH_W       = $clog2(IN_W);
  localparam int DIFF_W     = OUT_W + 1;
  localparam int PROD_W     = DIFF_W + IN_W + 1;

  typedef logic [OUT_W-1:0] ord_t;

  typedef struct packed {
    logic [SEG_W-1:0] seg;
    logic [SH_W-1:0]  sh;
    logic [IN_W-1:0]  off;
  } seg_t;
endpackage

// File: rtl/gamma_knot_bank.sv
module gamma_knot_bank
  import gamma_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           frame_active,
  input  logic                           fade_req,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [OUT_W-1:0]               wr_data,
  output logic [NKNOT-1:0][OUT_W-1:0]    act_y,
  output logic                           act_fade
);
  logic [NKNOT-1:0][OUT_W-1:0] pend_q, pend_d, act_q;
  logic                        fade_q;
  logic                        load_en;

  assign load_en = !frame_active;

  for (genvar i = 0; i < NKNOT; i++) begin : g_knot
    always_comb begin
      pend_d[i] = pend_q[i];
      if (wr_en && (wr_addr == ADDR_W'(i))) pend_d[i] = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
      fade_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (load_en) begin
        act_q  <= pend_q;
        fade_q <= fade_req;
      end
    end
  end

  assign act_y    = act_q;
  assign act_fade = fade_q;

  // R7: active curve frozen while a frame streams
  a_r7_hold_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    frame_active |=> ($stable(act_q) && $stable(fade_q)));

  // R6: out-of-range writes leave every pending knot untouched
  a_r6_bad_addr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr >= ADDR_W'(NKNOT))) |=> $stable(pend_q));
endmodule

// File: rtl/gamma_seg_decode.sv
module gamma_seg_decode
  import gamma_pkg::*;
(
  input  logic [IN_W-1:0] x_i,
  output seg_t            seg_o
);
  always_comb begin
    seg_o.seg = SEG_W'(x_i >> FINE_LOG);
    seg_o.sh  = SH_W'(FINE_LOG);
    seg_o.off = x_i & IN_W'((1 << FINE_LOG) - 1);
    for (int p = OCT_FIRST; p < IN_W; p++) begin
      if (x_i[p]) begin
        seg_o.seg = SEG_W'(FINE_SEGS + (p - OCT_FIRST) * SUBDIV
                           + 32'(x_i[p-1 -: SUBDIV_LOG]));
        seg_o.sh  = SH_W'(p - SUBDIV_LOG);
        seg_o.off = x_i & ((IN_W'(1) << (p - SUBDIV_LOG)) - IN_W'(1));
      end
    end
  end
endmodule

// File: rtl/gamma_interp.sv
module gamma_interp
  import gamma_pkg::*;
(
  input  logic [OUT_W-1:0] y0_i,
  input  logic [OUT_W-1:0] y1_i,
  input  logic [IN_W-1:0]  off_i,
  input  logic [SH_W-1:0]  sh_i,
  output logic [OUT_W-1:0] y_o
);
  logic signed [DIFF_W-1:0] diff;
  logic signed [PROD_W-1:0] diff_x, off_x, prod, step;
  logic signed [PROD_W:0]   sum;

  always_comb begin
    diff   = $signed({1'b0, y1_i}) - $signed({1'b0, y0_i});
    diff_x = PROD_W'(diff);
    off_x  = PROD_W'({1'b0, off_i});
    prod   = diff_x * off_x;
    step   = prod >>> sh_i;
    sum    = (PROD_W+1)'(step) + (PROD_W+1)'($signed({1'b0, y0_i}));
    if (sum < 0)
      y_o = '0;
    else if (sum > (PROD_W+1)'((1 << OUT_W) - 1))
      y_o = '1;
    else
      y_o = sum[OUT_W-1:0];
  end
endmodule

// File: rtl/gamma_pwl.sv
module gamma_pwl
  import gamma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_active,
  input  logic              fade_black,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [OUT_W-1:0]  wr_data,
  input  logic              in_valid,
  input  logic [IN_W-1:0]   in_sample,
  output logic              out_valid,
  output logic [OUT_W-1:0]  out_sample
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic [NKNOT-1:0][OUT_W-1:0] act_y;
  logic                        act_fade;

  gamma_knot_bank u_bank (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .frame_active (frame_active),
    .fade_req     (fade_black),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .act_y        (act_y),
    .act_fade     (act_fade)
  );

  seg_t seg;

  gamma_seg_decode u_dec (
    .x_i   (in_sample),
    .seg_o (seg)
  );

  // stage 1: segment lookup
  logic [ADDR_W-1:0] idx_lo, idx_hi;
  ord_t              y0_d, y1_d;
  ord_t              y0_q, y1_q;
  logic [IN_W-1:0]   off_q;
  logic [SH_W-1:0]   sh_q;
  logic              v1_q;

  always_comb begin
    idx_lo = ADDR_W'(seg.seg);
    idx_hi = idx_lo + ADDR_W'(1);
    y0_d   = act_fade ? '0 : act_y[idx_lo];
    y1_d   = act_fade ? '0 : act_y[idx_hi];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      v1_q  <= 1'b0;
      y0_q  <= '0;
      y1_q  <= '0;
      off_q <= '0;
      sh_q  <= '0;
    end else begin
      v1_q <= in_valid;
      if (in_valid) begin
        y0_q  <= y0_d;
        y1_q  <= y1_d;
        off_q <= seg.off;
        sh_q  <= seg.sh;
      end
    end
  end

  // stage 2: interpolation
  ord_t interp_y;
  ord_t out_q;
  logic ov_q;

  gamma_interp u_interp (
    .y0_i  (y0_q),
    .y1_i  (y1_q),
    .off_i (off_q),
    .sh_i  (sh_q),
    .y_o   (interp_y)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ov_q  <= 1'b0;
      out_q <= '0;
    end else begin
      ov_q <= v1_q;
      if (v1_q) out_q <= interp_y;
    end
  end

  assign out_valid  = ov_q;
  assign out_sample = out_q;

  // R4: valid travels exactly two cycles
  a_r4_valid_follows: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> ##1 out_valid);
  a_r4_idle_follows: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> ##1 !out_valid);

  // R5: fade yields zero output
  a_r5_fade_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && act_fade) |=> ##1 (out_sample == '0));

  // R3: result lies between segment endpoints
  a_r3_between_ends: assert property (@(posedge clk) disable iff (!rst_sync_n)
    v1_q |=> (((out_sample >= $past(y0_q)) && (out_sample <= $past(y1_q))) ||
              ((out_sample <= $past(y0_q)) && (out_sample >= $past(y1_q)))));

  // R1: the decoded offset fits inside its segment
  a_r1_offset_in_seg: assert property (@(posedge clk) disable iff (!rst_sync_n)
    v1_q |-> ((off_q >> sh_q) == '0));
endmodule

// File: tb/gamma_pwl_tb.sv
module gamma_pwl_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       frame_active;
  logic       fade_black;
  logic       wr_en;
  logic [5:0] wr_addr;
  logic [9:0] wr_data;
  logic       in_valid;
  logic [11:0] in_sample;
  logic       out_valid;
  logic [9:0] out_sample;

  always #2.5 clk = ~clk;

  gamma_pwl u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_active (frame_active),
    .fade_black   (fade_black),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .in_valid     (in_valid),
    .in_sample    (in_sample),
    .out_valid    (out_valid),
    .out_sample   (out_sample)
  );

  int KX[33] = '{0, 8, 16, 24, 32, 40, 48, 56, 64, 80, 96, 112, 128, 160, 192, 224,
                 256, 320, 384, 448, 512, 640, 768, 896, 1024, 1280, 1536, 1792,
                 2048, 2560, 3072, 3584, 4096};

  int    checks = 0;
  int    errors = 0;
  int    pend_m[33];
  int    act_m[33];
  bit    fade_p = 1'b0;
  bit    fade_m = 1'b0;
  bit    pv[2];
  int    pe[2];
  string pr[2];
  string cur_req = "R8";
  int    seed_dummy;

  function automatic int ref_out(input int x);
    int k, w, d, off, num, q, r;
    if (fade_m) return 0;
    k = 0;
    for (int i = 0; i < 32; i++)
      if (x >= KX[i] && x < KX[i+1]) k = i;
    w   = KX[k+1] - KX[k];
    d   = act_m[k+1] - act_m[k];
    off = x - KX[k];
    num = d * off;
    if (num >= 0) q = num / w;
    else          q = -((-num + w - 1) / w);
    r = act_m[k] + q;
    if (r < 0) r = 0;
    if (r > 1023) r = 1023;
    return r;
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic step(input bit v, input int x, input bit we, input int wa, input int wd);
    @(negedge clk);
    chk("R4 valid", int'(out_valid), int'(pv[1]));
    if (pv[1]) chk(pr[1], int'(out_sample), pe[1]);
    pv[1] = pv[0]; pe[1] = pe[0]; pr[1] = pr[0];
    in_valid  = v;
    in_sample = x[11:0];
    wr_en     = we;
    wr_addr   = wa[5:0];
    wr_data   = wd[9:0];
    if (we && wa < 33) pend_m[wa] = wd;
    pv[0] = v;
    pe[0] = v ? ref_out(x) : 0;
    pr[0] = cur_req;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 0, 1'b0, 0, 0);
  endtask

  task automatic settle();
    frame_active = 1'b0;
    idle(3);
    for (int i = 0; i < 33; i++) act_m[i] = pend_m[i];
    fade_m = fade_p;
  endtask

  task automatic load_curve(input int mode);
    for (int i = 0; i < 33; i++) begin
      int v;
      case (mode)
        0:       v = i * 31;
        1:       v = 1023 - i * 31;
        default: v = int'($urandom_range(1023));
      endcase
      step(1'b0, 0, 1'b1, i, v);
    end
  endtask

  task automatic stream_rand(input int n, input int gap_pct);
    for (int i = 0; i < n; i++) begin
      bit v = ($urandom_range(99) >= gap_pct);
      step(v, int'($urandom_range(4095)), 1'b0, 0, 0);
    end
  endtask

  task automatic stream_knots();
    for (int i = 0; i < 33; i++) begin
      int x = (KX[i] > 4095) ? 4095 : KX[i];
      step(1'b1, x, 1'b0, 0, 0);
      if (x < 4095) step(1'b1, x + 1, 1'b0, 0, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    seed_dummy = $urandom(32'd2718);
    for (int i = 0; i < 33; i++) begin pend_m[i] = 0; act_m[i] = 0; end
    pv[0] = 1'b0; pv[1] = 1'b0; pe[0] = 0; pe[1] = 0; pr[0] = "R8"; pr[1] = "R8";
    rst_n = 1'b0; frame_active = 1'b0; fade_black = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; in_valid = 1'b0; in_sample = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R8: reset state, zero curve
    cur_req = "R8";
    idle(4);
    frame_active = 1'b1;
    stream_rand(12, 0);
    stream_knots();

    // R1 R2: rising ramp, every knot and one past it
    cur_req = "R1 R2 ramp";
    settle();
    load_curve(0);
    settle();
    frame_active = 1'b1;
    stream_knots();
    cur_req = "R1 ramp random";
    stream_rand(200, 0);

    // R3: falling curve
    cur_req = "R3 falling";
    settle();
    load_curve(1);
    settle();
    frame_active = 1'b1;
    stream_knots();
    stream_rand(200, 0);

    // R3 R1: random non-monotonic curves
    for (int c = 0; c < 6; c++) begin
      cur_req = "R3 random curve";
      settle();
      load_curve(2);
      settle();
      frame_active = 1'b1;
      stream_knots();
      stream_rand(300, 10);
    end

    // R6: writes beyond the last knot change nothing
    cur_req = "R6 bad addr";
    step(1'b0, 0, 1'b1, 33, 1023);
    step(1'b0, 0, 1'b1, 40, 777);
    step(1'b0, 0, 1'b1, 63, 5);
    step(1'b0, 0, 1'b1, 48, 321);
    settle();
    frame_active = 1'b1;
    stream_knots();

    // R7: mid-frame writes and fade request are deferred
    cur_req = "R7 deferred";
    frame_active = 1'b1;
    step(1'b0, 0, 1'b1, 0, 900);
    step(1'b0, 0, 1'b1, 16, 3);
    step(1'b0, 0, 1'b1, 32, 511);
    fade_black = 1'b1; fade_p = 1'b1;
    stream_rand(150, 0);
    stream_knots();

    // R5: fade applied after the frame boundary
    cur_req = "R5 fade";
    settle();
    frame_active = 1'b1;
    stream_rand(200, 0);
    stream_knots();

    // R7: new knots visible once fade is released between frames
    cur_req = "R7 applied";
    fade_black = 1'b0; fade_p = 1'b0;
    settle();
    frame_active = 1'b1;
    stream_knots();
    stream_rand(200, 0);

    // R4: sparse valid pattern
    cur_req = "R4 gaps";
    stream_rand(400, 60);
    idle(4);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule